// File: doc/BRIEF.md
# SPI Register Transaction Master with Device Wait States

This block is a SPI master that runs one register access at a time against an attached security device. A host asks for a read or a write by giving a direction, a 24-bit register address and a byte count from 1 to 64. Write bytes are then pulled from the host one at a time, and read bytes are handed back one at a time. Every access starts with a four-byte command header. The device may stall the access after the header, and the engine then polls with dummy bytes until the device reports that it is ready. Only after that does the payload move.

Two conditions change the normal flow. The first is device sleep. On the first access after reset, and on any access that follows a long quiet period, the engine first drops chip select briefly with no clocks, to wake the device. It then waits before it sends the real header. The second is a device that never becomes ready. When the polling window runs out, the engine ends the access with an error. For a read it still delivers the requested number of bytes, all of them zero, so the host can always count on a fixed number of data beats.

All times are set in microseconds and scaled by the system clock frequency parameter. The SPI clock comes from a divider of the system clock.

Top module: `sreg_xact`

## Requirements
- R1: Header byte 0 has bit 7 = 1 for a read and 0 for a write, bit 6 = 1, and bits 5:0 = byte count minus one. A read of 4 bytes therefore sends 0xC3, and a write of 1 byte sends 0x40.
- R2: Header bytes 1, 2 and 3 carry address bits 23:16, 15:8 and 7:0, in that order.
- R3: The SPI link runs in mode 0. SCLK idles low and is low whenever chip select changes. Each byte goes out MSB first. The master samples MISO on the rising edge and changes MOSI only on the falling edge.
- R4: Chip select (active low) falls once per access and stays low through the header, any polling and the whole payload. It rises after the last payload byte, so each access forms exactly one chip-select frame.
- R5: If MISO is 1 on the eighth bit of the fourth header byte, the payload starts at once, with no dummy byte in between.
- R6: If that bit is 0, the master sends whole 0x00 bytes. It looks at the eighth received bit of each one and starts the payload right after the first byte in which that bit is 1.
- R7: If the device is still not ready when the polling window (POLL_LIMIT_US) has run out, the master releases chip select and ends with the error flag set. A write then takes no write bytes. A read then delivers byte-count bytes of 0x00.
- R8: The first access after reset starts with a wake pulse. Chip select is low for exactly WAKE_LO_US worth of system clocks, with no SCLK edge. It is then high for exactly WAKE_GAP_US worth of clocks, and then the header frame begins.
- R9: An access that follows more than IDLE_LIMIT_US of idle time also starts with a wake pulse. An access that follows a shorter idle time does not.
- R10: reqReady is high only while the engine is idle. A request is taken when reqValid and reqReady are both high, and reqValid is ignored while an access is running. Each access ends with a one-cycle doneP, and doneErr may be high only together with doneP.
- R11: Write bytes are taken with a wrValid/wrReady handshake and sent in order. Read bytes are offered with rdValid/rdReady. rdData holds steady until it is taken, the bytes come out in order, and the dummy byte sent while reading is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Request present |
| reqRead | input | 1 | 1 = register read, 0 = register write |
| reqAddr | input | 24 | Register address |
| reqLen | input | 7 | Byte count, 1 to 64 |
| reqReady | output | 1 | Engine idle, request can be taken |
| wrValid | input | 1 | Write byte present |
| wrData | input | 8 | Write byte |
| wrReady | output | 1 | Engine takes the write byte this cycle |
| rdValid | output | 1 | Read byte present |
| rdData | output | 8 | Read byte |
| rdReady | input | 1 | Host takes the read byte |
| doneP | output | 1 | One-cycle pulse at the end of an access |
| doneErr | output | 1 | Polling timed out; valid with doneP |
| sclk | output | 1 | SPI clock, idles low |
| csN | output | 1 | Chip select, active low |
| mosi | output | 1 | Data to the device |
| miso | input | 1 | Data from the device |

## Verification
The bench drives the access types that most easily go wrong. A device that stalls for one or for three poll bytes shows whether the ready bit is taken from the right bit position. A design that looked at the wrong bit would skip polling or poll forever. A device that never becomes ready shows whether chip select is released and whether exactly the byte count of zero bytes comes back. A design that got this wrong would hang or leave the read stream short. Wake-pulse widths and gaps are counted to the cycle, both on the first access and after a long idle time, and a quick follow-up access is checked for the absence of any pulse. A slow host on both byte streams, and a second request held while the engine is busy, check that the engine neither drops nor repeats bytes and never starts a second frame.

// File: rtl/sreg_pkg.sv
package sreg_pkg;
  // The frame header limits one access to this many payload bytes.
  localparam int FRAME_MAX = 64;

  typedef struct packed {
    logic       start;
    logic [7:0] txByte;
  } dpCmd_t;

  typedef struct packed {
    logic       busy;
    logic       done;
    logic [7:0] rxByte;
  } dpStat_t;

  typedef enum logic [3:0] {
    ST_IDLE, ST_WAKE_LO, ST_WAKE_GAP, ST_HDR, ST_POLL,
    ST_PAY_WR, ST_PAY_RD, ST_FILL, ST_DRAIN
  } state_t;
endpackage

// File: rtl/sreg_dpath.sv
module sreg_dpath
  import sreg_pkg::*;
#(
  parameter int HALF_DIV = 2
) (
  input  logic    clk,
  input  logic    rstN,
  input  dpCmd_t  cmd,
  output dpStat_t stat,
  output logic    sclk,
  output logic    mosi,
  input  logic    miso
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  logic [CW-1:0] phase;
  logic [2:0]    bitIdx;
  logic [7:0]    txSh;
  logic [7:0]    rxSh;
  logic          busy;
  logic          doneQ;
  logic          sclkQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase  <= '0;
      bitIdx <= '0;
      txSh   <= '0;
      rxSh   <= '0;
      busy   <= 1'b0;
      doneQ  <= 1'b0;
      sclkQ  <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      if (cmd.start && !busy) begin
        busy   <= 1'b1;
        txSh   <= cmd.txByte;
        phase  <= '0;
        bitIdx <= '0;
        sclkQ  <= 1'b0;
      end else if (busy) begin
        if (phase == CW'(HALF_DIV - 1)) begin
          phase <= '0;
          if (!sclkQ) begin
            sclkQ <= 1'b1;                 // rising edge: sample the device
            rxSh  <= {rxSh[6:0], miso};
          end else begin
            sclkQ <= 1'b0;                 // falling edge: present next bit
            if (bitIdx == 3'd7) begin
              busy  <= 1'b0;
              doneQ <= 1'b1;
            end else begin
              bitIdx <= bitIdx + 3'd1;
              txSh   <= {txSh[6:0], 1'b0};
            end
          end
        end else begin
          phase <= phase + CW'(1);
        end
      end
    end
  end

  assign sclk        = sclkQ;
  assign mosi        = txSh[7];
  assign stat.busy   = busy;
  assign stat.done   = doneQ;
  assign stat.rxByte = rxSh;

  // R3: the clock rests low whenever no byte is on the wire
  a_r3_idle_low: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !sclkQ);
endmodule

// File: rtl/sreg_ctrl.sv
module sreg_ctrl
  import sreg_pkg::*;
#(
  parameter int WAKE_LO_CYC  = 50,
  parameter int WAKE_GAP_CYC = 5000,
  parameter int POLL_CYC     = 5000000,
  parameter int IDLE_CYC     = 45000000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        reqRead,
  input  logic [23:0] reqAddr,
  input  logic [6:0]  reqLen,
  output logic        reqReady,
  input  logic        wrValid,
  input  logic [7:0]  wrData,
  output logic        wrReady,
  output logic        rdValid,
  output logic [7:0]  rdData,
  input  logic        rdReady,
  output logic        doneP,
  output logic        doneErr,
  output logic        csN,
  output dpCmd_t      cmd,
  input  dpStat_t     stat
);
  localparam int M1    = (WAKE_LO_CYC > WAKE_GAP_CYC) ? WAKE_LO_CYC : WAKE_GAP_CYC;
  localparam int T_MAX = (POLL_CYC > M1) ? POLL_CYC : M1;
  localparam int TW    = $clog2(T_MAX + 2);
  localparam int IW    = $clog2(IDLE_CYC + 1);
  localparam int NW    = $clog2(FRAME_MAX);

  state_t        state;
  logic [TW-1:0] tmr;
  logic [IW-1:0] idleCnt;
  logic          seenQ;
  logic          isRead;
  logic [23:0]   addrQ;
  logic [NW-1:0] lenM1;
  logic [NW-1:0] cnt;
  logic          pend;
  logic          startQ;
  logic [7:0]    txQ;
  logic          csQ;
  logic          rdValidQ;
  logic [7:0]    rdDataQ;
  logic          doneQ;
  logic          errQ;
  logic          wakeNeed;

  function automatic logic [7:0] hdrByte(input logic [1:0] idx);
    case (idx)
      2'd0:    hdrByte = {isRead, 1'b1, lenM1};
      2'd1:    hdrByte = addrQ[23:16];
      2'd2:    hdrByte = addrQ[15:8];
      default: hdrByte = addrQ[7:0];
    endcase
  endfunction

  assign wakeNeed = !seenQ || (idleCnt == IW'(IDLE_CYC));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      tmr      <= '0;
      idleCnt  <= '0;
      seenQ    <= 1'b0;
      isRead   <= 1'b0;
      addrQ    <= '0;
      lenM1    <= '0;
      cnt      <= '0;
      pend     <= 1'b0;
      startQ   <= 1'b0;
      txQ      <= '0;
      csQ      <= 1'b1;
      rdValidQ <= 1'b0;
      rdDataQ  <= '0;
      doneQ    <= 1'b0;
      errQ     <= 1'b0;
    end else begin
      doneQ  <= 1'b0;
      startQ <= 1'b0;
      if (rdValidQ && rdReady) rdValidQ <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (idleCnt != IW'(IDLE_CYC)) idleCnt <= idleCnt + IW'(1);
          if (reqValid) begin
            isRead  <= reqRead;
            addrQ   <= reqAddr;
            lenM1   <= NW'(reqLen - 7'd1);
            seenQ   <= 1'b1;
            idleCnt <= '0;
            tmr     <= '0;
            cnt     <= '0;
            errQ    <= 1'b0;
            csQ     <= 1'b0;
            if (wakeNeed) begin
              state <= ST_WAKE_LO;
            end else begin
              state  <= ST_HDR;
              startQ <= 1'b1;
              txQ    <= {reqRead, 1'b1, NW'(reqLen - 7'd1)};
            end
          end
        end
        ST_WAKE_LO: begin
          if (tmr == TW'(WAKE_LO_CYC - 1)) begin
            csQ   <= 1'b1;
            tmr   <= '0;
            state <= ST_WAKE_GAP;
          end else tmr <= tmr + TW'(1);
        end
        ST_WAKE_GAP: begin
          if (tmr == TW'(WAKE_GAP_CYC - 1)) begin
            csQ    <= 1'b0;
            state  <= ST_HDR;
            startQ <= 1'b1;
            txQ    <= hdrByte(2'd0);
          end else tmr <= tmr + TW'(1);
        end
        ST_HDR: begin
          if (stat.done) begin
            if (cnt == NW'(3)) begin
              tmr <= '0;
              cnt <= '0;
              if (stat.rxByte[0]) begin
                state <= isRead ? ST_PAY_RD : ST_PAY_WR;
              end else begin
                state  <= ST_POLL;
                startQ <= 1'b1;
                txQ    <= 8'h00;
              end
            end else begin
              cnt    <= cnt + NW'(1);
              startQ <= 1'b1;
              txQ    <= hdrByte(cnt[1:0] + 2'd1);
            end
          end
        end
        ST_POLL: begin
          if (tmr != {TW{1'b1}}) tmr <= tmr + TW'(1);
          if (stat.done) begin
            if (stat.rxByte[0]) begin
              state <= isRead ? ST_PAY_RD : ST_PAY_WR;
            end else if (tmr >= TW'(POLL_CYC)) begin
              csQ   <= 1'b1;
              errQ  <= 1'b1;
              state <= isRead ? ST_FILL : ST_DRAIN;
            end else begin
              startQ <= 1'b1;
              txQ    <= 8'h00;
            end
          end
        end
        ST_PAY_WR: begin
          if (!pend && wrValid) begin
            pend   <= 1'b1;
            startQ <= 1'b1;
            txQ    <= wrData;
          end
          if (stat.done) begin
            pend <= 1'b0;
            if (cnt == lenM1) begin
              csQ   <= 1'b1;
              state <= ST_DRAIN;
            end else cnt <= cnt + NW'(1);
          end
        end
        ST_PAY_RD: begin
          if (!pend && !rdValidQ) begin
            pend   <= 1'b1;
            startQ <= 1'b1;
            txQ    <= 8'h00;
          end
          if (stat.done) begin
            pend     <= 1'b0;
            rdDataQ  <= stat.rxByte;
            rdValidQ <= 1'b1;
            if (cnt == lenM1) begin
              csQ   <= 1'b1;
              state <= ST_DRAIN;
            end else cnt <= cnt + NW'(1);
          end
        end
        ST_FILL: begin
          if (!rdValidQ) begin
            rdDataQ  <= 8'h00;
            rdValidQ <= 1'b1;
            if (cnt == lenM1) state <= ST_DRAIN;
            else cnt <= cnt + NW'(1);
          end
        end
        ST_DRAIN: begin
          if (!rdValidQ) begin
            doneQ <= 1'b1;
            state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign reqReady   = (state == ST_IDLE);
  assign wrReady    = (state == ST_PAY_WR) && !pend;
  assign rdValid    = rdValidQ;
  assign rdData     = rdDataQ;
  assign doneP      = doneQ;
  assign doneErr    = doneQ && errQ;
  assign csN        = csQ;
  assign cmd.start  = startQ;
  assign cmd.txByte = txQ;

  // R8: no byte is shifted while the wake pulse or its gap is running
  a_r8_wake_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WAKE_LO || state == ST_WAKE_GAP) |-> !stat.busy);
  // R11: write bytes are only pulled during a write access
  a_r11_wr_dir: assert property (@(posedge clk) disable iff (!rstN)
    wrReady |-> !isRead);
endmodule

// File: rtl/sreg_xact.sv
module sreg_xact
  import sreg_pkg::*;
#(
  parameter int CLK_HZ        = 50000000,
  parameter int SCLK_HALF     = 2,
  parameter int WAKE_LO_US    = 1,
  parameter int WAKE_GAP_US   = 100,
  parameter int POLL_LIMIT_US = 100000,
  parameter int IDLE_LIMIT_US = 900000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        reqRead,
  input  logic [23:0] reqAddr,
  input  logic [6:0]  reqLen,
  output logic        reqReady,
  input  logic        wrValid,
  input  logic [7:0]  wrData,
  output logic        wrReady,
  output logic        rdValid,
  output logic [7:0]  rdData,
  input  logic        rdReady,
  output logic        doneP,
  output logic        doneErr,
  output logic        sclk,
  output logic        csN,
  output logic        mosi,
  input  logic        miso
);
  localparam int PER_US   = (CLK_HZ / 1000000 > 0) ? CLK_HZ / 1000000 : 1;
  localparam int LO_CYC   = (PER_US * WAKE_LO_US > 0) ? PER_US * WAKE_LO_US : 1;
  localparam int GAP_CYC  = (PER_US * WAKE_GAP_US > 0) ? PER_US * WAKE_GAP_US : 1;
  localparam int POLL_CYC = PER_US * POLL_LIMIT_US;
  localparam int IDLE_CYC = PER_US * IDLE_LIMIT_US;

  dpCmd_t  dpCmd;
  dpStat_t dpStat;

  sreg_ctrl #(
    .WAKE_LO_CYC (LO_CYC),
    .WAKE_GAP_CYC(GAP_CYC),
    .POLL_CYC    (POLL_CYC),
    .IDLE_CYC    (IDLE_CYC)
  ) u_ctrl (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqRead(reqRead), .reqAddr(reqAddr), .reqLen(reqLen),
    .reqReady(reqReady),
    .wrValid(wrValid), .wrData(wrData), .wrReady(wrReady),
    .rdValid(rdValid), .rdData(rdData), .rdReady(rdReady),
    .doneP(doneP), .doneErr(doneErr), .csN(csN),
    .cmd(dpCmd), .stat(dpStat)
  );

  sreg_dpath #(.HALF_DIV(SCLK_HALF)) u_dp (
    .clk(clk), .rstN(rstN), .cmd(dpCmd), .stat(dpStat),
    .sclk(sclk), .mosi(mosi), .miso(miso)
  );

  // R4: no SCLK activity outside a selected frame
  a_r4_clk_in_frame: assert property (@(posedge clk) disable iff (!rstN)
    sclk |-> !csN);
  // R4: select stays asserted while any byte is being shifted
  a_r4_cs_held: assert property (@(posedge clk) disable iff (!rstN)
    dpStat.busy |-> !csN);
  // R10: a taken request makes the engine busy on the next cycle
  a_r10_accept_once: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);
  // R10: error flag only alongside the end pulse
  a_r10_err_with_done: assert property (@(posedge clk) disable iff (!rstN)
    doneErr |-> doneP);
  // R11: an offered read byte holds until taken
  a_r11_rd_hold: assert property (@(posedge clk) disable iff (!rstN)
    (rdValid && !rdReady) |=> (rdValid && $stable(rdData)));
endmodule

// File: tb/sim_sreg_xact.sv
module sim_sreg_xact;
  localparam int CLK_HZ = 4000000;
  localparam int WLO    = 4;    // 1 us at 4 cycles per us
  localparam int WGAP   = 20;   // 5 us

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqRead = 1'b0;
  logic [23:0] reqAddr = '0;
  logic [6:0] reqLen = 7'd1;
  logic reqReady, wrReady, rdValid, doneP, doneErr, sclk, csN, mosi;
  logic wrValid = 1'b0;
  logic [7:0] wrData = '0;
  logic rdReady = 1'b1;
  logic [7:0] rdData;
  logic misoQ = 1'b0;

  int checks = 0, fails = 0, cyc = 0;
  int devBits = 0, devWait = 0;
  logic [7:0] devSh = '0;
  logic [7:0] devRx[$];
  logic [7:0] devResp[64];
  logic [7:0] wrBuf[64];
  logic [7:0] expQ[$];
  int wrPtr = 0, wrCount = 0;
  bit wrTook = 0, wrGaps = 0, rdSlow = 0;
  int wakeEvents = 0, csSegments = 0, lastWakeW = 0, lastGapW = 0;
  int lowCnt = 0, highCnt = 0;
  bit lastWasWake = 0;
  logic prevCs = 1'b1;
  string curTag = "R11";

  always #10 clk = ~clk;

  sreg_xact #(
    .CLK_HZ(CLK_HZ), .SCLK_HALF(2), .WAKE_LO_US(1), .WAKE_GAP_US(5),
    .POLL_LIMIT_US(100), .IDLE_LIMIT_US(300)
  ) u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqRead(reqRead),
    .reqAddr(reqAddr), .reqLen(reqLen), .reqReady(reqReady),
    .wrValid(wrValid), .wrData(wrData), .wrReady(wrReady),
    .rdValid(rdValid), .rdData(rdData), .rdReady(rdReady),
    .doneP(doneP), .doneErr(doneErr), .sclk(sclk), .csN(csN),
    .mosi(mosi), .miso(misoQ)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // device model: what the device puts on MISO for global bit b of a frame
  function automatic logic devMisoBit(input int b);
    int k = b / 8;
    int j = b % 8;
    if (k < 3) return 1'b0;
    if (k == 3) return (j == 7) && (devWait == 0);
    if (devWait < 0) return 1'b0;
    if (k < 4 + devWait) return (j == 7) && (k - 4 == devWait - 1);
    if (k - 4 - devWait < 64) return devResp[k - 4 - devWait][7 - j];
    return 1'b0;
  endfunction

  initial forever begin
    @(negedge csN);
    devBits = 0;
    misoQ = devMisoBit(0);
  end
  initial forever begin
    @(posedge sclk);
    if (!csN) begin
      devSh = {devSh[6:0], mosi};
      devBits++;
      if (devBits % 8 == 0) devRx.push_back(devSh);
    end
  end
  initial forever begin
    @(negedge sclk);
    if (!csN) misoQ = devMisoBit(devBits);
  end

  // host streams, scoreboard monitor and chip-select timing
  initial forever begin
    @(negedge clk);
    cyc++;
    if (csN !== prevCs) begin
      chk(sclk == 1'b0, "R3", "sclk at select edge", sclk, 0);
      if (csN) begin
        if (devBits == 0) begin wakeEvents++; lastWakeW = lowCnt; lastWasWake = 1; end
        else begin csSegments++; lastWasWake = 0; end
        highCnt = 0;
      end else begin
        if (lastWasWake) lastGapW = highCnt;
        lowCnt = 0;
      end
    end
    if (!csN) lowCnt++; else highCnt++;
    prevCs = csN;

    if (wrTook) wrPtr++;
    wrValid = (wrPtr < wrCount) && !(wrGaps && (cyc % 3 == 0));
    wrData  = wrBuf[(wrPtr < 64) ? wrPtr : 0];
    wrTook  = wrValid && wrReady;

    rdReady = !(rdSlow && (cyc % 3 == 1));
    if (rdValid && rdReady) begin
      if (expQ.size() == 0) chk(1'b0, curTag, "unexpected read byte", rdData, 0);
      else begin
        logic [7:0] e;
        e = expQ.pop_front();
        chk(rdData == e, curTag, "read byte", rdData, e);
      end
    end
  end

  task automatic tick();
    @(negedge clk);
    #2;
  endtask

  task automatic runXact(input bit rd, input logic [23:0] a, input int len,
                         input int waitN, input bit expErr, input bit expWake,
                         input string wakeTag, input bit slow);
    int w0, s0, total, nPoll;
    bit seen;
    bit err;
    logic [7:0] hb0;
    devWait = waitN;
    devRx.delete();
    w0 = wakeEvents;
    s0 = csSegments;
    for (int i = 0; i < 64; i++) begin
      devResp[i] = 8'(a[7:0] + i * 29 + 3);
      wrBuf[i]   = 8'(8'hA5 ^ (i * 7 + len));
    end
    rdSlow = slow; wrGaps = slow;
    wrPtr = 0; wrTook = 0; wrCount = rd ? 0 : len;
    curTag = expErr ? "R7" : "R11";
    if (rd) for (int i = 0; i < len; i++) expQ.push_back(expErr ? 8'h00 : devResp[i]);
    reqValid = 1'b1; reqRead = rd; reqAddr = a; reqLen = 7'(len);
    tick();
    reqValid = 1'b0;
    tick();
    // R10: a second request while busy must be ignored
    reqValid = 1'b1; reqAddr = ~a; reqRead = ~rd;
    tick();
    chk(reqReady == 1'b0, "R10", "reqReady while busy", reqReady, 0);
    tick();
    reqValid = 1'b0;
    seen = 0; err = 0;
    for (int i = 0; i < 20000 && !seen; i++) begin
      tick();
      if (doneP) begin seen = 1; err = doneErr; end
    end
    tick();
    chk(seen, "R10", "done pulse seen", seen, 1);
    chk(err == expErr, expErr ? "R7" : "R10", "error flag", err, expErr);
    chk(csN == 1'b1, "R4", "select released", csN, 1);
    chk(csSegments - s0 == 1, "R4", "one select frame", csSegments - s0, 1);
    chk(wakeEvents - w0 == int'(expWake), wakeTag, "wake pulses", wakeEvents - w0, expWake);
    if (expWake) begin
      chk(lastWakeW == WLO, wakeTag, "wake low width", lastWakeW, WLO);
      chk(lastGapW == WGAP, wakeTag, "wake gap width", lastGapW, WGAP);
    end
    hb0 = {rd, 1'b1, 6'(len - 1)};
    chk(devRx.size() >= 4, "R1", "header length", devRx.size(), 4);
    if (devRx.size() >= 4) begin
      chk(devRx[0] == hb0, "R1", "header byte 0", devRx[0], hb0);
      chk(devRx[1] == a[23:16], "R2", "address high", devRx[1], a[23:16]);
      chk(devRx[2] == a[15:8], "R2", "address mid", devRx[2], a[15:8]);
      chk(devRx[3] == a[7:0], "R2", "address low", devRx[3], a[7:0]);
    end
    if (!expErr) begin
      total = 4 + waitN + len;
      chk(devRx.size() == total, (waitN == 0) ? "R5" : "R6", "bytes in frame",
          devRx.size(), total);
      for (int i = 0; i < waitN; i++)
        chk(devRx[4 + i] == 8'h00, "R6", "poll byte", devRx[4 + i], 0);
      for (int i = 0; i < len; i++) begin
        if (rd) chk(devRx[4 + waitN + i] == 8'h00, "R11", "read dummy", devRx[4 + waitN + i], 0);
        else chk(devRx[4 + waitN + i] == wrBuf[i], "R11", "write byte", devRx[4 + waitN + i], wrBuf[i]);
      end
      if (!rd) chk(wrPtr == len, "R11", "write bytes taken", wrPtr, len);
    end else begin
      nPoll = devRx.size() - 4;
      chk(nPoll >= 12 && nPoll <= 14, "R7", "poll bytes before timeout", nPoll, 13);
      for (int i = 4; i < devRx.size(); i++)
        chk(devRx[i] == 8'h00, "R7", "poll byte", devRx[i], 0);
      if (!rd) chk(wrPtr == 0, "R7", "write bytes taken", wrPtr, 0);
    end
    chk(expQ.size() == 0, curTag, "read bytes left over", expQ.size(), 0);
    rdSlow = 0; wrGaps = 0; wrCount = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (4) tick();
    chk(csN == 1'b1, "R4", "select idle in reset", csN, 1);
    chk(sclk == 1'b0, "R3", "sclk low in reset", sclk, 0);
    chk(reqReady == 1'b1, "R10", "ready in reset", reqReady, 1);
    chk(doneP == 1'b0, "R10", "no done in reset", doneP, 0);
    rstN = 1'b1;
    repeat (3) tick();

    runXact(1'b1, 24'hD40F00, 4, 0, 1'b0, 1'b1, "R8", 1'b0);
    runXact(1'b0, 24'hD40018, 1, 0, 1'b0, 1'b0, "R9", 1'b0);
    runXact(1'b1, 24'hD40024, 64, 3, 1'b0, 1'b0, "R9", 1'b1);
    runXact(1'b0, 24'hD40024, 5, 1, 1'b0, 1'b0, "R9", 1'b1);
    runXact(1'b1, 24'hD40000, 3, -1, 1'b1, 1'b0, "R9", 1'b0);
    runXact(1'b0, 24'h123456, 2, -1, 1'b1, 1'b0, "R9", 1'b0);
    repeat (1400) tick();
    runXact(1'b1, 24'hABCDEF, 2, 0, 1'b0, 1'b1, "R9", 1'b0);
    repeat (100) tick();
    runXact(1'b1, 24'h00F904, 1, 2, 1'b0, 1'b0, "R9", 1'b1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule